// File: doc/BRIEF.md
# Character LCD Nibble Port

This block is a memory-mapped port that lets software drive a character display controller over a 4-bit parallel bus. On the register side it has a simple 32-bit bus with a wait signal. Software writes a word to the command register or to the data register. Each write sends one nibble, taken from bits 7:4 of the word, to the display. The register-select line is low for a command write and high for a data write.

Reading the command register starts a two-nibble read of the display's status and address byte. The high nibble is fetched first. Once it has been captured, the block sets a raw valid flag and may raise an interrupt. The low nibble is fetched only after software has cleared the valid flag. It sets the valid flag again but never raises the interrupt, so software polls for it. The block times every enable strobe, including the setup and hold of select and data around it, with clock-cycle counts given as parameters. Software assembles the byte itself: the busy flag is bit 7 of the result, which is the top bit of the first nibble.

Top module: `lcd_nibble_port`

## Requirements
- R1: After reset the enable strobe is low, the interrupt is low, the bus is ready, and the read-data, raw, mask and masked-status registers all read zero.
- R2: A write to offset 0x00 (command) or 0x04 (data) produces exactly one enable strobe. During that strobe the LCD data lines carry bits 7:4 of the written word, read/write is low, and register-select is 0 for command and 1 for data.
- R3: Register-select, read/write and the data lines are driven for SETUP_CYC cycles before the strobe rises. They stay stable while the strobe is high and for HOLD_CYC cycles after it falls. The strobe stays high for exactly STROBE_CYC cycles.
- R4: While a transfer or a read cycle is in progress, a command or data write, or a command read, holds bus_ready low until the block is idle. The access is then performed, not dropped.
- R5: A read of offset 0x00 runs a strobe with read/write high and register-select low. The block samples the display's data lines in the last cycle of the strobe.
- R6: After each captured nibble, bit 8 of the raw register (0x0C) reads 1. The read-data register (0x08) returns the nibble in bits 7:4, with all other bits zero. The high nibble comes first.
- R7: The second (low) nibble strobe does not start until the raw valid flag has been cleared after the first nibble.
- R8: Writing 0x00000000 to the raw register clears the valid flag. Writing any other value to it has no effect.
- R9: The interrupt output and bit 0 of the masked-status register (0x14) are 1 exactly when all three hold: the raw valid flag is set, bit 0 of the mask register (0x10) is set, and the last captured nibble was the first nibble of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_ready | output | 1 | Access completes in a cycle where bus_sel and bus_ready are both high |
| irq | output | 1 | Interrupt request |
| lcd_rs | output | 1 | Register select: 0 for command/status, 1 for data |
| lcd_rw | output | 1 | 1 = read from display |
| lcd_en | output | 1 | Enable strobe |
| lcd_d_out | output | 4 | Nibble driven toward the display |
| lcd_d_oe | output | 1 | Output enable for the data lines |
| lcd_d_in | input | 4 | Nibble returned by the display |

## Verification
The bench builds the block with SETUP_CYC = 2, STROBE_CYC = 3 and HOLD_CYC = 2, instead of the default counts sized for a 450 ns strobe. This keeps each transfer to a few cycles, so the strobe width can be counted exactly and a second write can be placed while the first is still in flight. Short transfers also let the bench hold the inter-nibble gap open for many cycles, to show that the low nibble waits for the valid flag to be cleared.

// File: rtl/lcd_nibble_port.sv
module lcd_nibble_port #(
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 60,
  parameter int HOLD_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        irq,
  output logic        lcd_rs,
  output logic        lcd_rw,
  output logic        lcd_en,
  output logic [3:0]  lcd_d_out,
  output logic        lcd_d_oe,
  input  logic [3:0]  lcd_d_in
);
  localparam int MAXC = (STROBE_CYC > SETUP_CYC) ?
                        ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC) :
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, HOLD, GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          rs_q, rw_q, second_q, valid_q, hi_q, mask_q;
  logic [3:0]    dq, nib_q;

  logic [2:0] sel_reg;
  assign sel_reg = bus_addr[4:2];

  logic hit_cmd, hit_dat, hit_raw, hit_msk, needs_fsm, go, wr;
  assign hit_cmd   = sel_reg == 3'd0;
  assign hit_dat   = sel_reg == 3'd1;
  assign hit_raw   = sel_reg == 3'd3;
  assign hit_msk   = sel_reg == 3'd4;
  assign wr        = bus_sel & bus_wr;
  assign needs_fsm = bus_sel & (bus_wr ? (hit_cmd | hit_dat) : hit_cmd);
  assign bus_ready = !(needs_fsm && st != IDLE);
  assign go        = needs_fsm && st == IDLE;

  assign irq       = valid_q & hi_q & mask_q;
  assign lcd_en    = st == STROBE;
  assign lcd_rs    = rs_q;
  assign lcd_rw    = rw_q;
  assign lcd_d_out = dq;
  assign lcd_d_oe  = ~rw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; rs_q <= 1'b0; rw_q <= 1'b0; dq <= '0;
      second_q <= 1'b0; valid_q <= 1'b0; hi_q <= 1'b0; nib_q <= '0;
      mask_q <= 1'b0;
    end else begin
      if (wr && hit_msk) mask_q <= bus_wdata[0];
      if (wr && hit_raw && bus_wdata == 32'd0) begin
        valid_q <= 1'b0;
        hi_q    <= 1'b0;
      end
      case (st)
        IDLE: if (go) begin
          st       <= SETUP;
          cnt      <= CW'(SETUP_CYC - 1);
          rs_q     <= bus_wr & hit_dat;
          rw_q     <= ~bus_wr;
          dq       <= bus_wr ? bus_wdata[7:4] : 4'd0;
          second_q <= 1'b0;
        end
        SETUP: if (cnt == '0) begin
          st  <= STROBE;
          cnt <= CW'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        STROBE: if (cnt == '0) begin
          st  <= HOLD;
          cnt <= CW'(HOLD_CYC - 1);
          if (rw_q) begin
            nib_q   <= lcd_d_in;
            valid_q <= 1'b1;
            hi_q    <= ~second_q;
          end
        end else cnt <= cnt - 1'b1;
        HOLD: if (cnt == '0) begin
          if (rw_q && !second_q) st <= GAP;
          else begin
            st   <= IDLE;
            rw_q <= 1'b0;
          end
        end else cnt <= cnt - 1'b1;
        GAP: if (!valid_q) begin
          st       <= SETUP;
          cnt      <= CW'(SETUP_CYC - 1);
          second_q <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel_reg)
      3'd2: bus_rdata[7:4] = nib_q;
      3'd3: bus_rdata[8]   = valid_q;
      3'd4: bus_rdata[0]   = mask_q;
      3'd5: bus_rdata[0]   = irq;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lcd_nibble_port_chk.sv
module lcd_nibble_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [4:0]  bus_addr,
  input logic        bus_ready,
  input logic        irq,
  input logic        lcd_rs,
  input logic        lcd_rw,
  input logic        lcd_en,
  input logic [3:0]  lcd_d_out,
  input logic        valid_q,
  input logic        mask_q
);
  assert_stable_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |=> (!lcd_en || ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out))));

  assert_setup_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)));

  assert_hold_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)));

  assert_wait_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && bus_sel && bus_wr && bus_addr[4:3] == 2'b00) |-> !bus_ready);

  assert_irq_needs_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (valid_q && mask_q));

  assert_capture_sets_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcd_en) && lcd_rw) |-> valid_q);
endmodule

bind lcd_nibble_port lcd_nibble_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_ready(bus_ready), .irq(irq), .lcd_rs(lcd_rs),
  .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_d_out(lcd_d_out),
  .valid_q(valid_q), .mask_q(mask_q)
);

// File: tb/test_lcd_nibble_port.sv
module test_lcd_nibble_port;
  localparam int SU = 2, EN = 3, HO = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, irq, lcd_rs, lcd_rw, lcd_en, lcd_d_oe;
  logic [3:0] lcd_d_out, lcd_d_in = 4'h0;

  always #4 clk = ~clk;

  lcd_nibble_port #(.SETUP_CYC(SU), .STROBE_CYC(EN), .HOLD_CYC(HO)) i_lcd_nibble_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  int tests = 0, fails = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // strobe monitor
  int n_str = 0, cur_len = 0;
  logic [3:0] s_d[32];
  logic s_rs[32], s_rw[32];
  int s_len[32];
  always @(negedge clk) begin
    if (lcd_en) begin
      cur_len++;
      if (n_str < 32) begin s_d[n_str] = lcd_d_out; s_rs[n_str] = lcd_rs; s_rw[n_str] = lcd_rw; end
    end else if (cur_len != 0) begin
      if (n_str < 32) s_len[n_str] = cur_len;
      n_str++;
      cur_len = 0;
    end
  end

  task automatic bus_acc(input logic w, input logic [4:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) @(negedge clk);
    rd = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int NV = 4;
  localparam logic [41:0] VEC [NV] = '{
    {5'h00, 32'h0000_0038, 1'b0, 4'h3},
    {5'h04, 32'h0000_00A7, 1'b1, 4'hA},
    {5'h00, 32'hFFFF_FF5C, 1'b0, 4'h5},
    {5'h04, 32'h0000_0F0F, 1'b1, 4'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 en", {31'd0, lcd_en}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 ready", {31'd0, bus_ready}, 1);
    bus_acc(0, 5'h08, 0, r); check("R1 rdata", r, 0);
    bus_acc(0, 5'h0C, 0, r); check("R1 raw", r, 0);
    bus_acc(0, 5'h10, 0, r); check("R1 mask", r, 0);
    bus_acc(0, 5'h14, 0, r); check("R1 stat", r, 0);

    // R2 R3: vector walk
    for (int i = 0; i < NV; i++) begin
      base = n_str;
      bus_acc(1, VEC[i][41:37], VEC[i][36:5], r);
      idle_wait(SU + EN + HO + 3);
      check("R2 one strobe", n_str - base, 1);
      check("R2 nibble", {28'd0, s_d[base]}, {28'd0, VEC[i][3:0]});
      check("R2 rs", {31'd0, s_rs[base]}, {31'd0, VEC[i][4]});
      check("R2 rw low", {31'd0, s_rw[base]}, 0);
      check("R3 strobe width", s_len[base], EN);
    end

    // R4 back-pressure: second write issued while first in flight
    base = n_str;
    bus_acc(1, 5'h00, 32'h90, r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h60;
    #1 check("R4 ready low while busy", {31'd0, bus_ready}, 0);
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
    idle_wait(SU + EN + HO + 3);
    check("R4 both strobes", n_str - base, 2);
    check("R4 second nibble kept", {28'd0, s_d[base+1]}, 32'h6);
    check("R4 second rs", {31'd0, s_rs[base+1]}, 1);

    // R5 R6 R7 R8 R9 read cycle
    bus_acc(1, 5'h10, 32'h1, r);
    lcd_d_in = 4'hA;
    base = n_str;
    bus_acc(0, 5'h00, 0, r);
    idle_wait(SU + EN + HO + 3);
    check("R5 one read strobe", n_str - base, 1);
    check("R5 rw high", {31'd0, s_rw[base]}, 1);
    check("R5 rs low", {31'd0, s_rs[base]}, 0);
    check("R9 irq on high nibble", {31'd0, irq}, 1);
    bus_acc(0, 5'h14, 0, r); check("R9 masked stat", r, 1);
    bus_acc(0, 5'h0C, 0, r); check("R6 raw valid", r, 32'h100);
    bus_acc(0, 5'h08, 0, r); check("R6 high nibble", r, 32'hA0);
    lcd_d_in = 4'h5;
    bus_acc(1, 5'h0C, 32'h100, r);
    idle_wait(20);
    bus_acc(0, 5'h0C, 0, r); check("R8 nonzero write ignored", r, 32'h100);
    check("R7 low nibble waits", n_str - base, 1);
    bus_acc(1, 5'h10, 32'h0, r);
    check("R9 masked off", {31'd0, irq}, 0);
    bus_acc(1, 5'h10, 32'h1, r);
    check("R9 unmasked again", {31'd0, irq}, 1);
    bus_acc(1, 5'h0C, 32'h0, r);
    check("R8 zero write clears irq", {31'd0, irq}, 0);
    idle_wait(SU + EN + HO + 4);
    check("R7 low nibble strobe", n_str - base, 2);
    check("R5 low rw high", {31'd0, s_rw[base+1]}, 1);
    bus_acc(0, 5'h0C, 0, r); check("R6 raw valid low nibble", r, 32'h100);
    check("R9 no irq on low nibble", {31'd0, irq}, 0);
    bus_acc(0, 5'h14, 0, r); check("R9 stat low nibble", r, 0);
    bus_acc(0, 5'h08, 0, r); check("R6 low nibble", r, 32'h50);
    bus_acc(1, 5'h0C, 32'h0, r);
    bus_acc(0, 5'h0C, 0, r); check("R8 cleared", r, 0);
    check("R4 idle ready", {31'd0, bus_ready}, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule